// File: doc/BRIEF.md
# Asynchronous SRAM Access Sequencer

This block sits between an internal clocked bus and an external asynchronous static RAM of 128K bytes. Each request is a single byte read or a single byte write. The block turns it into a timed sequence on the RAM pins: a pair of chip selects (one active low, one active high), an output strobe, a write strobe, a 17-bit address and an 8-bit data bus. The data bus is split into an output value, an output enable and an input value. The chip pad ring joins these three signals into the real bidirectional pins.

Every analogue limit is given in nanoseconds as a parameter. From these and the clock period, the block works out whole cycle counts by rounding up. The limits are: access time, output-strobe access time, write pulse width, data setup before the end of the write, turn-off time of the RAM outputs, cycle time and the power-up wait. After reset the block holds off all traffic until the power-up wait has passed. Between accesses it leaves the RAM deselected, which puts the RAM in standby.

Top module: `sram_async_ctrl`

## Requirements
- R1: While reset is held and on the first cycle after it, the RAM is deselected (`sram_cs_n`=1, `sram_cs`=0), `sram_rd_n`=1, `sram_wr_n`=1, `sram_dq_oe`=0, and `req_ready`=0.
- R2: `req_ready` stays 0 for at least PWRUP cycles after reset is released (PWRUP = ceil(T_PWRUP_NS/CLK_NS)). It rises within two cycles after that.
- R3: Whenever no access is in progress, the RAM is deselected (`sram_cs_n`=1, `sram_cs`=0).
- R4: A read holds the RAM selected, with `sram_rd_n`=0 and `sram_wr_n`=1, for RD cycles, where RD = max(ceil(T_AA_NS/CLK_NS), ceil(T_OE_NS/CLK_NS), ceil(T_RC_NS/CLK_NS)). `sram_dq_in` is captured on the last of these cycles and presented on `rsp_rdata`.
- R5: A write first selects the RAM for one cycle with both strobes high. It then holds `sram_wr_n`=0 for WP cycles, where WP = max(ceil(T_WP_NS/CLK_NS), ceil(T_SD_NS/CLK_NS), ceil(T_WC_NS/CLK_NS)-2). It then keeps the RAM selected for one more cycle with `sram_wr_n`=1. The write data is driven and stable through the whole pulse and that last cycle.
- R6: `sram_dq_oe` is 1 only while `sram_rd_n` is 1. At least HZ = ceil(T_HZ_NS/CLK_NS) cycles separate the rise of `sram_rd_n` from the next cycle with `sram_dq_oe`=1. The two strobes are never low together.
- R7: `rsp_done` is a one-cycle pulse. It follows the accepting clock edge by RD edges for a read and by WP+2 edges for a write. `req_ready` is 0 from acceptance until the block is idle again.
- R8: The address on `sram_addr` does not change while the RAM stays selected.
- R9: A read of an address returns the byte most recently written to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Byte address |
| req_wdata | input | 8 | Write byte |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 8 | Read byte, valid with and after `rsp_done` of a read |
| sram_cs_n | output | 1 | Active-low chip select to the RAM |
| sram_cs | output | 1 | Active-high chip select to the RAM |
| sram_rd_n | output | 1 | Active-low output strobe to the RAM |
| sram_wr_n | output | 1 | Active-low write strobe to the RAM |
| sram_addr | output | 17 | RAM address |
| sram_dq_out | output | 8 | Data driven toward the RAM |
| sram_dq_oe | output | 1 | Enable for the data pad drivers |
| sram_dq_in | input | 8 | Data read back from the RAM pins |

## Verification
The bench keeps the default 10 ns clock and the default nanosecond limits, which give RD=5, WP=4 and HZ=2. It shortens the power-up wait to 1000 ns, so the power-up edge is reached in 100 cycles. The RAM model in the bench returns a wrong value until the access time has run out, and it refuses a write whose pulse or data setup falls short. So a shortened count shows up as bad readback. A sweep over 48 addresses with every read-after-write and write-after-read ordering exercises each turnaround at the minimum spacing.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_PWR      = 3'd0,
        ST_IDLE     = 3'd1,
        ST_RD       = 3'd2,
        ST_RD_REL   = 3'd3,
        ST_WR_SET   = 3'd4,
        ST_WR_PULSE = 3'd5,
        ST_WR_HOLD  = 3'd6
    } ctrl_st_e;

    // Whole clock cycles covering a nanosecond limit, never below one.
    function automatic int unsigned ns_to_cyc(int unsigned ns, int unsigned period);
        if (ns == 0) return 1;
        return (ns + period - 1) / period;
    endfunction

    function automatic int unsigned umax(int unsigned a, int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_pwrup_timer.sv
module sram_pwrup_timer #(
    parameter int unsigned CYC = 100
) (
    input  logic clk,
    input  logic rst_n,
    output logic pwr_ok
);
    localparam int unsigned W = $clog2(CYC + 1);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (cnt_q != W'(CYC)) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign pwr_ok = (cnt_q == W'(CYC));

    // once the wait is over it stays over (R2)
    p_pwr_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_ok |=> pwr_ok);

endmodule

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
    parameter int unsigned W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)               cnt_d = load_val;
        else if (cnt_q != '0)   cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == '0);

    // the count only moves down between loads (R4, R5)
    p_count_down_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(load) && $past(cnt_q) != '0) |-> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int unsigned ADDR_W      = 17,
    parameter int unsigned DATA_W      = 8,
    parameter int unsigned CLK_NS      = 10,
    parameter int unsigned T_AA_NS     = 45,
    parameter int unsigned T_OE_NS     = 22,
    parameter int unsigned T_RC_NS     = 45,
    parameter int unsigned T_WC_NS     = 45,
    parameter int unsigned T_WP_NS     = 35,
    parameter int unsigned T_SD_NS     = 25,
    parameter int unsigned T_HZ_NS     = 18,
    parameter int unsigned T_PWRUP_NS  = 200000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_done,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              sram_cs_n,
    output logic              sram_cs,
    output logic              sram_rd_n,
    output logic              sram_wr_n,
    output logic [ADDR_W-1:0] sram_addr,
    output logic [DATA_W-1:0] sram_dq_out,
    output logic              sram_dq_oe,
    input  logic [DATA_W-1:0] sram_dq_in
);
    localparam int unsigned RD_CYC = umax(umax(ns_to_cyc(T_AA_NS, CLK_NS),
                                               ns_to_cyc(T_OE_NS, CLK_NS)),
                                          ns_to_cyc(T_RC_NS, CLK_NS));
    localparam int unsigned WC_CYC = ns_to_cyc(T_WC_NS, CLK_NS);
    localparam int unsigned WP_MIN = umax(ns_to_cyc(T_WP_NS, CLK_NS),
                                          ns_to_cyc(T_SD_NS, CLK_NS));
    localparam int unsigned WP_CYC = (WC_CYC > WP_MIN + 2) ? WC_CYC - 2 : WP_MIN;
    localparam int unsigned HZ_CYC = ns_to_cyc(T_HZ_NS, CLK_NS);
    localparam int unsigned PWR_CYC = ns_to_cyc(T_PWRUP_NS, CLK_NS);
    localparam int unsigned TMR_MAX = umax(umax(RD_CYC, WP_CYC), HZ_CYC);
    localparam int unsigned TMR_W = $clog2(TMR_MAX + 1);

    typedef struct packed {
        ctrl_st_e           st;
        logic               cs_n;
        logic               cs;
        logic               rd_n;
        logic               wr_n;
        logic [ADDR_W-1:0]  addr;
        logic [DATA_W-1:0]  wdata;
        logic               dq_oe;
        logic [DATA_W-1:0]  rdata;
        logic               done;
    } ctrl_t;

    localparam ctrl_t CTRL_RST = '{
        st: ST_PWR, cs_n: 1'b1, cs: 1'b0, rd_n: 1'b1, wr_n: 1'b1,
        addr: '0, wdata: '0, dq_oe: 1'b0, rdata: '0, done: 1'b0
    };

    ctrl_t             d, q;
    logic              pwr_ok;
    logic              tmr_load;
    logic [TMR_W-1:0]  tmr_val;
    logic              tmr_exp;

    sram_pwrup_timer #(.CYC(PWR_CYC)) u_pwrup (
        .clk    (clk),
        .rst_n  (rst_n),
        .pwr_ok (pwr_ok)
    );

    sram_phase_timer #(.W(TMR_W)) u_phase (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_exp)
    );

    always_comb begin
        d        = q;
        d.done   = 1'b0;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (q.st)
            ST_PWR: begin
                if (pwr_ok) d.st = ST_IDLE;
            end
            ST_IDLE: begin
                if (req_valid) begin
                    d.addr  = req_addr;
                    d.wdata = req_wdata;
                    d.cs_n  = 1'b0;
                    d.cs    = 1'b1;
                    if (req_write) begin
                        d.st = ST_WR_SET;
                    end else begin
                        d.st     = ST_RD;
                        d.rd_n   = 1'b0;
                        tmr_load = 1'b1;
                        tmr_val  = TMR_W'(RD_CYC - 1);
                    end
                end
            end
            ST_RD: begin
                if (tmr_exp) begin
                    d.rdata  = sram_dq_in;
                    d.done   = 1'b1;
                    d.st     = ST_RD_REL;
                    d.rd_n   = 1'b1;
                    d.cs_n   = 1'b1;
                    d.cs     = 1'b0;
                    tmr_load = 1'b1;
                    tmr_val  = TMR_W'(HZ_CYC - 1);
                end
            end
            ST_RD_REL: begin
                if (tmr_exp) d.st = ST_IDLE;
            end
            ST_WR_SET: begin
                d.st     = ST_WR_PULSE;
                d.wr_n   = 1'b0;
                d.dq_oe  = 1'b1;
                tmr_load = 1'b1;
                tmr_val  = TMR_W'(WP_CYC - 1);
            end
            ST_WR_PULSE: begin
                if (tmr_exp) begin
                    d.st   = ST_WR_HOLD;
                    d.wr_n = 1'b1;
                end
            end
            ST_WR_HOLD: begin
                d.st    = ST_IDLE;
                d.dq_oe = 1'b0;
                d.cs_n  = 1'b1;
                d.cs    = 1'b0;
                d.done  = 1'b1;
            end
            default: d = CTRL_RST;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= CTRL_RST;
        else        q <= d;
    end

    assign req_ready   = (q.st == ST_IDLE);
    assign rsp_done    = q.done;
    assign rsp_rdata   = q.rdata;
    assign sram_cs_n   = q.cs_n;
    assign sram_cs     = q.cs;
    assign sram_rd_n   = q.rd_n;
    assign sram_wr_n   = q.wr_n;
    assign sram_addr   = q.addr;
    assign sram_dq_out = q.wdata;
    assign sram_dq_oe  = q.dq_oe;

    logic selected;
    assign selected = !q.cs_n && q.cs;

    // the pad drivers never fight the RAM outputs (R6)
    p_no_drive_on_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
        sram_dq_oe |-> sram_rd_n);

    // both strobes are never low together (R6)
    p_strobe_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(!sram_rd_n && !sram_wr_n));

    // the data bus is only driven two cycles or more after rd_n rises (R6)
    p_turnaround_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sram_dq_oe) |-> ($past(sram_rd_n) && $past(sram_rd_n, 2)));

    // the write strobe only falls while the RAM is selected (R5)
    p_wr_selected_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_wr_n |-> selected);

    // the write data holds through the whole pulse (R5)
    p_wdata_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (sram_dq_oe && $past(sram_dq_oe)) |-> $stable(sram_dq_out));

    // the address holds while selected (R8)
    p_addr_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (selected && $past(selected)) |-> $stable(sram_addr));

    // standby whenever idle (R3)
    p_standby_r3: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (sram_cs_n && !sram_cs));

    // the done strobe lasts a single cycle (R7)
    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);

    // no traffic before the power-up wait ends (R2)
    p_pwr_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> pwr_ok);

endmodule

// File: tb/test_sram_async_ctrl.sv
module test_sram_async_ctrl;
    localparam int CLK_NS = 10;
    localparam int PWR_NS = 1000;
    localparam int PWR = (PWR_NS + CLK_NS - 1) / CLK_NS;
    localparam int RD  = 5;    // max(ceil(45/10), ceil(22/10), ceil(45/10))
    localparam int WP  = 4;    // max(ceil(35/10), ceil(25/10), ceil(45/10)-2)
    localparam int HZ  = 2;    // ceil(18/10)
    localparam int NADR = 48;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [16:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        rsp_done;
    logic [7:0]  rsp_rdata;
    logic        sram_cs_n, sram_cs, sram_rd_n, sram_wr_n, sram_dq_oe;
    logic [16:0] sram_addr;
    logic [7:0]  sram_dq_out;
    logic [7:0]  sram_dq_in;

    int tests = 0;
    int fails = 0;
    bit finished = 1'b0;

    always #(CLK_NS / 2) clk = ~clk;

    sram_async_ctrl #(.CLK_NS(CLK_NS), .T_PWRUP_NS(PWR_NS)) i_sram_async_ctrl (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
        .sram_cs_n(sram_cs_n), .sram_cs(sram_cs), .sram_rd_n(sram_rd_n),
        .sram_wr_n(sram_wr_n), .sram_addr(sram_addr), .sram_dq_out(sram_dq_out),
        .sram_dq_oe(sram_dq_oe), .sram_dq_in(sram_dq_in)
    );

    // ---------------- RAM model with timing limits, sampled at negedges
    logic [7:0]  mem [0:255];
    int          rd_age = 0;
    int          wr_low = 0;
    int          d_stab = 0;
    int          rd_hi  = 100;
    logic [16:0] last_addr = '0;
    logic [7:0]  last_dq = '0;
    bit          last_sel = 1'b0;
    bit          last_wr = 1'b0;
    int v_contend = 0, v_hz = 0, v_wr = 0, v_addr = 0, v_strobe = 0, v_idle = 0;

    wire model_sel = !sram_cs_n && sram_cs;
    wire model_rd  = model_sel && !sram_rd_n && sram_wr_n;

    assign sram_dq_in = (model_rd && rd_age * CLK_NS >= 45) ? mem[sram_addr[7:0]] : 8'h5A;

    initial for (int i = 0; i < 256; i++) mem[i] = 8'h00;

    always @(negedge clk) if (rst_n) begin
        if (model_rd) rd_age <= (last_sel && sram_addr == last_addr) ? rd_age + 1 : 1;
        else          rd_age <= 0;
        if (sram_rd_n) rd_hi <= rd_hi + 1; else rd_hi <= 0;
        if (sram_dq_oe && model_rd) v_contend <= v_contend + 1;
        if (sram_dq_oe && rd_hi < HZ) v_hz <= v_hz + 1;
        if (!sram_rd_n && !sram_wr_n) v_strobe <= v_strobe + 1;
        if (model_sel && last_sel && sram_addr != last_addr) v_addr <= v_addr + 1;
        if (req_ready && model_sel) v_idle <= v_idle + 1;
        if (model_sel && !sram_wr_n) begin
            wr_low <= wr_low + 1;
            d_stab <= (sram_dq_oe && sram_dq_out == last_dq && last_wr) ? d_stab + 1 :
                      (sram_dq_oe ? 1 : 0);
        end else if (last_wr) begin
            // write ends: check pulse width and data setup before committing
            if (wr_low * CLK_NS >= 35 && d_stab * CLK_NS >= 25)
                mem[last_addr[7:0]] <= last_dq;
            else
                v_wr <= v_wr + 1;
            wr_low <= 0;
            d_stab <= 0;
        end
        last_sel  <= model_sel;
        last_wr   <= model_sel && !sram_wr_n;
        last_addr <= sram_addr;
        last_dq   <= sram_dq_out;
    end

    // ---------------- checking helpers
    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [16:0] addr_of(int i);
        return 17'((i & 255) | ((i * 37) << 9));
    endfunction

    function automatic logic [7:0] data_of(int i, int salt);
        return 8'((i * 29 + salt * 71 + 3) ^ 8'hC3);
    endfunction

    task automatic do_op(input bit wr, input logic [16:0] a, input logic [7:0] wd,
                         output logic [7:0] rd, output int lat);
        int n;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = wd;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        check("R7 ready drops while busy", 32'(req_ready), 32'd0);
        n = 1;
        while (!rsp_done && n < 50) begin @(negedge clk); n++; end
        lat = n - 1;
        rd = rsp_rdata;
        @(negedge clk);
        check("R7 done single pulse", 32'(rsp_done), 32'd0);
    endtask

    initial begin
        logic [7:0] rd;
        int lat;
        int n;
        #(3 * CLK_NS);
        // R1: reset state
        check("R1 cs_n in reset", 32'(sram_cs_n), 32'd1);
        check("R1 cs in reset", 32'(sram_cs), 32'd0);
        check("R1 rd_n in reset", 32'(sram_rd_n), 32'd1);
        check("R1 wr_n in reset", 32'(sram_wr_n), 32'd1);
        check("R1 dq_oe in reset", 32'(sram_dq_oe), 32'd0);
        check("R1 ready in reset", 32'(req_ready), 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        // R2: power-up wait, counted in edges after release
        n = 0;
        while (!req_ready && n < PWR + 20) begin @(posedge clk); n++; #1; end
        check("R2 ready not before power-up", 32'(n >= PWR), 32'd1);
        check("R2 ready soon after power-up", 32'(n <= PWR + 2), 32'd1);
        check("R3 standby when idle", 32'({sram_cs_n, sram_cs}), 32'b10);

        // R5/R7: write sweep
        for (int i = 0; i < NADR; i++) begin
            do_op(1'b1, addr_of(i), data_of(i, 0), rd, lat);
            check("R7 write latency", 32'(lat), 32'(WP + 2));
        end
        // R4/R7/R9: read sweep in reverse order
        for (int i = NADR - 1; i >= 0; i--) begin
            do_op(1'b0, addr_of(i), 8'h00, rd, lat);
            check("R7 read latency", 32'(lat), 32'(RD));
            check("R9 readback", 32'(rd), 32'(data_of(i, 0)));
        end
        // R6/R9: alternating write then read, with write-after-read turnarounds
        for (int i = 0; i < NADR; i++) begin
            do_op(1'b1, addr_of(i), data_of(i, 1), rd, lat);
            do_op(1'b0, addr_of(i), 8'h00, rd, lat);
            check("R9 readback after overwrite", 32'(rd), 32'(data_of(i, 1)));
        end
        @(negedge clk);
        check("R3 standby after traffic", 32'({sram_cs_n, sram_cs}), 32'b10);
        check("R3 no selection while ready", 32'(v_idle), 32'd0);
        check("R4 strobes never both low", 32'(v_strobe), 32'd0);
        check("R5 write pulse and setup", 32'(v_wr), 32'd0);
        check("R6 no contention", 32'(v_contend), 32'd0);
        check("R6 turnaround gap", 32'(v_hz), 32'd0);
        check("R8 address stable", 32'(v_addr), 32'd0);
        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(150000 * CLK_NS);
        if (!finished) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule